// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block models the device side of a parallel NOR-flash command interface in front of a small on-chip word array. A host drives three chip-enable lines, an active-low output enable, an active-low write enable, an address and a 16-bit data word. Writes are decoded as commands. The commands select one of four read modes, start a two-write word program, or clear the error flags in the status register.

A word program is a setup command followed by an address/data write. A parameterized busy counter stands in for the internal write engine. While the counter runs, the ready flag reads 0 and any further writes are dropped. A program can only pull array bits from 1 to 0. It is refused, with a distinct pair of error flags, when the program-voltage-valid input is low or when the target block's lock input is set. After a program sequence, reads keep returning status until the host writes a different command.

The device clock samples every bus signal. A command is taken on the first clock where write enable is seen high after having been low while the device is selected. The address and data present at that moment are captured.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the read mode is array read, every array word is 0xFFFF, the status register reads 0x0080 and the busy output is low.
- R2: The data bus enable is high only when all three chip enables are 1, output enable is 0 and write enable is 1; otherwise it is 0.
- R3: The command code is taken from data bits 7:0. 0xFF selects array read. 0x90 selects identifier read: word 0 returns 0x0089, word 1 returns 0x0017 and any other word returns 0. 0x98 selects query read: words 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059 and any other word returns 0. 0x70 selects status read, which returns the status register in bits 7:0 with bits 15:8 zero.
- R4: A setup write of 0x40, or the alternate 0x10, followed by a second write programs the word at the second write's address with that write's data.
- R5: Once a setup or program write is accepted, reads return status until another read-mode command is written.
- R6: After an accepted program write, the busy output is high and status bit 7 is 0 for exactly BUSY_CYCLES clocks, and writes in that window are ignored.
- R7: A program write while the voltage-valid input is low sets status bits 4 and 3, leaves the array unchanged and starts no busy period. This check takes precedence over the lock check.
- R8: A program write to a block whose lock input bit is set sets status bits 4 and 1 and leaves the array unchanged. The block index is the top two address bits.
- R9: A program stores the bitwise AND of the old word and the write data, so a 1 written over a 0 leaves 0 and raises no error.
- R10: Error bits 5, 4, 3 and 1 stay set until the clear command 0x50, which clears them and leaves the read mode unchanged.
- R11: Any other command code sets status bits 5 and 4 and switches reads to status.
- R12: Write pulses while any chip enable is 0 change neither the array, the read mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 3 | Chip enables, all must be 1 to select |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | 6 | Word address |
| data_i | input | 16 | Write data from host |
| data_o | output | 16 | Read data to host |
| data_oe_o | output | 1 | Read data drive enable |
| vpp_ok_i | input | 1 | Program voltage valid |
| blk_lock_i | input | 4 | Per-block lock bits |
| sts_busy_o | output | 1 | High while a program runs |

## Verification
The program path is exercised with both setup codes, with data that clears bits in an erased word, and with data that tries to set bits already cleared. Together these separate the AND-only update from a plain overwrite. Refused programs are tried with low voltage alone, with a locked block alone, and with both at once. The status value read afterwards distinguishes the two error pairs and their order of precedence. Writes issued while busy, while deselected, and with an unknown code each show whether the mode, the array and the status stayed untouched.

// File: rtl/fci_pkg.sv
// Shared definitions for the flash command interface: command codes,
// read modes, decoded command kinds and status bit positions.
package fci_pkg;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_PROG      = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT  = 8'h10;

    localparam int SR_READY = 7;
    localparam int SR_SEQ   = 5;
    localparam int SR_PRG   = 4;
    localparam int SR_VPP   = 3;
    localparam int SR_LOCK  = 1;

    typedef enum logic [1:0] {
        M_ARRAY,
        M_IDENT,
        M_QUERY,
        M_STATUS
    } rd_mode_e;

    typedef enum logic [2:0] {
        K_ARRAY,
        K_IDENT,
        K_QUERY,
        K_STATUS,
        K_CLEAR,
        K_SETUP,
        K_BAD
    } cmd_kind_e;

endpackage

// File: rtl/fci_cmd_decode.sv
// Command decoder: classifies the low byte of a command write.
// Assumes it is only consulted for writes that are not program data.
module fci_cmd_decode
    import fci_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_kind_e  kind_o
);

    // Map the command byte to its kind; unknown codes become K_BAD.
    always_comb begin
        unique case (code_i)
            CMD_RD_ARRAY:            kind_o = K_ARRAY;
            CMD_RD_IDENT:            kind_o = K_IDENT;
            CMD_RD_QUERY:            kind_o = K_QUERY;
            CMD_RD_STATUS:           kind_o = K_STATUS;
            CMD_CLR_STAT:            kind_o = K_CLEAR;
            CMD_PROG, CMD_PROG_ALT:  kind_o = K_SETUP;
            default:                 kind_o = K_BAD;
        endcase
    end

endmodule

// File: rtl/fci_busy_timer.sv
// Busy timer: stands in for the internal write engine. A start pulse
// keeps busy high for BUSY_CYCLES clocks; done pulses in the last one.
// Assumes start is never raised while busy.
module fci_busy_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = busy_o && (cnt_q == CNT_W'(1));

    // Load on start, count down while busy, drop busy on the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= CNT_W'(BUSY_CYCLES);
            busy_o <= 1'b1;
        end else if (busy_o) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            busy_o <= !done_o;
        end
    end

    // R6: the top must never restart a running program
    p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/fci_status.sv
// Status register: sticky error flags plus a ready flag taken from the
// busy timer. Set requests win over a clear in the same cycle.
module fci_status
    import fci_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       clr_i,
    input  logic       set_vpp_i,
    input  logic       set_lock_i,
    input  logic       set_seq_i,
    output logic [7:0] sr_o
);

    logic seq_q, prg_q, vpp_q, lock_q;

    // Hold each error flag until a clear command arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= 1'b0;
            prg_q  <= 1'b0;
            vpp_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (clr_i) begin
                seq_q  <= 1'b0;
                prg_q  <= 1'b0;
                vpp_q  <= 1'b0;
                lock_q <= 1'b0;
            end
            if (set_seq_i)                          seq_q  <= 1'b1;
            if (set_vpp_i)                          vpp_q  <= 1'b1;
            if (set_lock_i)                         lock_q <= 1'b1;
            if (set_seq_i || set_vpp_i || set_lock_i) prg_q <= 1'b1;
        end
    end

    // Assemble the status byte.
    always_comb begin
        sr_o           = '0;
        sr_o[SR_READY] = !busy_i;
        sr_o[SR_SEQ]   = seq_q;
        sr_o[SR_PRG]   = prg_q;
        sr_o[SR_VPP]   = vpp_q;
        sr_o[SR_LOCK]  = lock_q;
    end

    // R7: a voltage refusal shows both flags on the next cycle
    p_vpp_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_vpp_i |=> (sr_o[SR_PRG] && sr_o[SR_VPP]));

    // R8: a lock refusal shows both flags on the next cycle
    p_lock_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_lock_i |=> (sr_o[SR_PRG] && sr_o[SR_LOCK]));

    // R10: the program error flag only falls through a clear
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_q && !clr_i) |=> prg_q);

endmodule

// File: rtl/fci_array.sv
// Word array: erased to all ones on reset, asynchronous read, and a
// write port that can only clear bits (stores old AND new).
module fci_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] old_word;

    assign rd_data_o = mem_q[rd_addr_i];
    assign old_word  = mem_q[wr_addr_i];

    // Erase on reset; otherwise clear the bits that the write data holds at 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= old_word & wr_data_i;
        end
    end

    // R9: a write never turns a 0 bit into a 1
    p_only_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((mem_q[$past(wr_addr_i)] & ~$past(old_word)) == '0));

endmodule

// File: rtl/fci_read_mux.sv
// Read data selection for the current read mode: array word,
// identifier words, a short query table or the status byte.
module fci_read_mux
    import fci_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter logic [15:0] MFG_ID = 16'h0089,
    parameter logic [15:0] DEV_ID = 16'h0017
) (
    input  rd_mode_e          mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       array_i,
    input  logic [7:0]        sr_i,
    output logic [15:0]       data_o
);

    // Pick the word the host sees for this mode and address.
    always_comb begin
        data_o = '0;
        unique case (mode_i)
            M_ARRAY:  data_o = array_i;
            M_IDENT: begin
                if (addr_i == ADDR_W'(0))      data_o = MFG_ID;
                else if (addr_i == ADDR_W'(1)) data_o = DEV_ID;
            end
            M_QUERY: begin
                if (addr_i == ADDR_W'(16))      data_o = 16'h0051;
                else if (addr_i == ADDR_W'(17)) data_o = 16'h0052;
                else if (addr_i == ADDR_W'(18)) data_o = 16'h0059;
            end
            M_STATUS: data_o = {8'h00, sr_i};
            default:  data_o = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_if.sv
// Flash command interface top. Samples the host bus on the device clock,
// takes a write on the first clock where write enable is seen high after
// low while selected, runs the command / program sequencing and drives
// read data. Assumes the host holds address and data across that clock.
module flash_cmd_if
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BLK_W       = 2,
    parameter int BUSY_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          ce_i,
    input  logic                oe_n_i,
    input  logic                we_n_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [15:0]         data_i,
    output logic [15:0]         data_o,
    output logic                data_oe_o,
    input  logic                vpp_ok_i,
    input  logic [(1<<BLK_W)-1:0] blk_lock_i,
    output logic                sts_busy_o
);

    logic             sel;
    logic             we_q;
    logic             wr_evt;
    logic             setup_q;
    rd_mode_e         mode_q;
    cmd_kind_e        kind;
    logic             busy, done;
    logic             prog_start, vpp_err, lock_err, seq_err, clr_req;
    logic [ADDR_W-1:0] pa_q;
    logic [15:0]      pd_q;
    logic [15:0]      array_rd;
    logic [7:0]       sr;
    logic [BLK_W-1:0] blk_idx;

    assign sel       = &ce_i;
    assign wr_evt    = sel && we_n_i && !we_q && !busy;
    assign data_oe_o = sel && !oe_n_i && we_n_i;
    assign blk_idx   = addr_i[ADDR_W-1 -: BLK_W];
    assign sts_busy_o = busy;

    // Remember the previous write-enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n_i;
    end

    fci_cmd_decode u_dec (
        .code_i (data_i[7:0]),
        .kind_o (kind)
    );

    // Classify the current write into program, refusal or command events.
    always_comb begin
        prog_start = 1'b0;
        vpp_err    = 1'b0;
        lock_err   = 1'b0;
        seq_err    = 1'b0;
        clr_req    = 1'b0;
        if (wr_evt) begin
            if (setup_q) begin
                if (!vpp_ok_i)               vpp_err    = 1'b1;
                else if (blk_lock_i[blk_idx]) lock_err   = 1'b1;
                else                         prog_start = 1'b1;
            end else begin
                seq_err = (kind == K_BAD);
                clr_req = (kind == K_CLEAR);
            end
        end
    end

    // Track the read mode and whether the next write is program data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_ARRAY;
            setup_q <= 1'b0;
        end else if (wr_evt) begin
            if (setup_q) begin
                setup_q <= 1'b0;
                mode_q  <= M_STATUS;
            end else begin
                unique case (kind)
                    K_ARRAY:  mode_q <= M_ARRAY;
                    K_IDENT:  mode_q <= M_IDENT;
                    K_QUERY:  mode_q <= M_QUERY;
                    K_STATUS: mode_q <= M_STATUS;
                    K_CLEAR:  mode_q <= mode_q;
                    K_SETUP: begin
                        setup_q <= 1'b1;
                        mode_q  <= M_STATUS;
                    end
                    default:  mode_q <= M_STATUS;
                endcase
            end
        end
    end

    // Capture the program target when a program is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q <= '0;
            pd_q <= '1;
        end else if (prog_start) begin
            pa_q <= addr_i;
            pd_q <= data_i;
        end
    end

    fci_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy),
        .done_o  (done)
    );

    fci_status u_sr (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy),
        .clr_i      (clr_req),
        .set_vpp_i  (vpp_err),
        .set_lock_i (lock_err),
        .set_seq_i  (seq_err),
        .sr_o       (sr)
    );

    fci_array #(.ADDR_W(ADDR_W), .DATA_W(16)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (addr_i),
        .rd_data_o (array_rd),
        .wr_en_i   (done),
        .wr_addr_i (pa_q),
        .wr_data_i (pd_q)
    );

    fci_read_mux #(.ADDR_W(ADDR_W)) u_mux (
        .mode_i  (mode_q),
        .addr_i  (addr_i),
        .array_i (array_rd),
        .sr_i    (sr),
        .data_o  (data_o)
    );

    // R1: the first cycle after reset is in array-read mode
    p_reset_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode_q == M_ARRAY && !busy));

    // R6: while the timer runs the status byte reports not ready
    p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sr[SR_READY]);

    // R8: a locked-block refusal never starts the timer
    p_lock_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> !busy);

    // R5: a program write always leaves reads in status mode
    p_status_after_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> (mode_q == M_STATUS));

endmodule

// File: tb/flash_cmd_if_tb_top.sv
// Directed bench for the flash command interface.
module flash_cmd_if_tb_top;

    localparam int BUSY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ce = 3'b000;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        doe;
    logic        vpp_ok = 1'b1;
    logic [3:0]  lock = 4'b0000;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_f = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_if #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_i       (ce),
        .oe_n_i     (oe_n),
        .we_n_i     (we_n),
        .addr_i     (addr),
        .data_i     (din),
        .data_o     (dout),
        .data_oe_o  (doe),
        .vpp_ok_i   (vpp_ok),
        .blk_lock_i (lock),
        .sts_busy_o (busy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [15:0] d,
                          input logic [2:0] cev = 3'b111);
        @(negedge clk);
        addr = a; din = d; ce = cev; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce = 3'b000;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; ce = 3'b111; oe_n = 1'b0;
        #1;
        v = dout;
        oe_n = 1'b1; ce = 3'b000;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        chk("R1 busy", 16'(busy), 16'h0);
        chk("R1 oe idle", 16'(doe), 16'h0);
        bus_rd(6'd0, v);  chk("R1 array word 0", v, 16'hFFFF);
        bus_rd(6'd63, v); chk("R1 array word 63", v, 16'hFFFF);
        bus_wr(6'd0, 16'h0070);
        bus_rd(6'd0, v);  chk("R1 status", v, 16'h0080);
    endtask

    task automatic t_gating();
        @(negedge clk);
        ce = 3'b110; oe_n = 1'b0; #1; chk("R2 partial ce", 16'(doe), 16'h0);
        ce = 3'b111; we_n = 1'b0; #1; chk("R2 we low", 16'(doe), 16'h0);
        we_n = 1'b1; #1;              chk("R2 selected", 16'(doe), 16'h1);
        oe_n = 1'b1; #1;              chk("R2 oe high", 16'(doe), 16'h0);
        ce = 3'b000;
    endtask

    task automatic t_modes();
        logic [15:0] v;
        bus_wr(6'd0, 16'h0090);
        bus_rd(6'd0, v);  chk("R3 ident mfg", v, 16'h0089);
        bus_rd(6'd1, v);  chk("R3 ident dev", v, 16'h0017);
        bus_wr(6'd0, 16'h0098);
        bus_rd(6'd17, v); chk("R3 query", v, 16'h0052);
        bus_wr(6'd0, 16'h0070);
        bus_rd(6'd3, v);  chk("R3 status", v, 16'h0080);
        bus_wr(6'd0, 16'h00FF);
        bus_rd(6'd5, v);  chk("R3 array", v, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [15:0] v;
        int cnt;
        bus_wr(6'd0, 16'h0040);
        @(negedge clk);
        addr = 6'd5; din = 16'h1234; ce = 3'b111; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!busy) break;
            cnt++;
            if (i == 2) begin
                oe_n = 1'b0; #1;
                chk("R6 status busy", dout, 16'h0000);
                oe_n = 1'b1;
            end
        end
        ce = 3'b000;
        chk("R6 busy length", 16'(cnt), 16'(BUSY));
        bus_rd(6'd0, v); chk("R5 status read 1", v, 16'h0080);
        bus_rd(6'd9, v); chk("R5 status read 2", v, 16'h0080);
        // alternate setup; write during busy must be ignored
        bus_wr(6'd0, 16'h0010);
        bus_wr(6'd6, 16'hA5A5);
        bus_wr(6'd0, 16'h00FF);
        wait_ready();
        bus_rd(6'd6, v); chk("R6 write in busy ignored", v, 16'h0080);
        bus_wr(6'd0, 16'h00FF);
        bus_rd(6'd5, v); chk("R4 programmed word", v, 16'h1234);
        bus_rd(6'd6, v); chk("R4 alternate setup", v, 16'hA5A5);
    endtask

    task automatic t_clear_only();
        logic [15:0] v;
        bus_wr(6'd0, 16'h0040);
        bus_wr(6'd5, 16'hFF0F);
        wait_ready();
        bus_rd(6'd0, v); chk("R9 no error", v, 16'h0080);
        bus_wr(6'd0, 16'h00FF);
        bus_rd(6'd5, v); chk("R9 and only", v, 16'h1204);
    endtask

    task automatic t_vpp();
        logic [15:0] v;
        vpp_ok = 1'b0;
        bus_wr(6'd0, 16'h0040);
        bus_wr(6'd7, 16'h0000);
        chk("R7 no busy", 16'(busy), 16'h0);
        bus_rd(6'd0, v); chk("R7 status", v, 16'h0098);
        vpp_ok = 1'b1;
        bus_wr(6'd0, 16'h00FF);
        bus_rd(6'd7, v); chk("R7 array kept", v, 16'hFFFF);
        bus_wr(6'd0, 16'h0070);
        bus_rd(6'd0, v); chk("R10 sticky", v, 16'h0098);
        bus_wr(6'd0, 16'h0050);
        bus_rd(6'd0, v); chk("R10 cleared", v, 16'h0080);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        lock = 4'b0010;
        bus_wr(6'd0, 16'h0040);
        bus_wr(6'd20, 16'h0000);
        bus_rd(6'd0, v); chk("R8 status", v, 16'h0092);
        bus_wr(6'd0, 16'h00FF);
        bus_rd(6'd20, v); chk("R8 array kept", v, 16'hFFFF);
        bus_wr(6'd0, 16'h0050);
        vpp_ok = 1'b0;
        bus_wr(6'd0, 16'h0040);
        bus_wr(6'd20, 16'h0000);
        bus_rd(6'd0, v); chk("R7 precedence over R8", v, 16'h0098);
        vpp_ok = 1'b1; lock = 4'b0000;
        bus_wr(6'd0, 16'h0050);
    endtask

    task automatic t_bad_cmd();
        logic [15:0] v;
        bus_wr(6'd0, 16'h00FF);
        bus_wr(6'd0, 16'h0033);
        bus_rd(6'd4, v); chk("R11 bad code", v, 16'h00B0);
        bus_wr(6'd0, 16'h0050);
        bus_rd(6'd4, v); chk("R10 mode kept on clear", v, 16'h0080);
    endtask

    task automatic t_deselect();
        logic [15:0] v;
        bus_wr(6'd0, 16'h00FF);
        bus_wr(6'd0, 16'h0070, 3'b101);
        bus_rd(6'd8, v); chk("R12 mode kept", v, 16'hFFFF);
        bus_wr(6'd0, 16'h0040, 3'b011);
        bus_wr(6'd8, 16'h0000, 3'b110);
        chk("R12 no busy", 16'(busy), 16'h0);
        bus_rd(6'd8, v); chk("R12 array kept", v, 16'hFFFF);
        bus_wr(6'd0, 16'h0033, 3'b100);
        bus_wr(6'd0, 16'h0070);
        bus_rd(6'd0, v); chk("R12 status kept", v, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gating();
        t_modes();
        t_program();
        t_clear_only();
        t_vpp();
        t_lock();
        t_bad_cmd();
        t_deselect();
        if (!done_f) begin
            done_f = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_f) begin
            done_f = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule